// File: doc/BRIEF.md
# Seconds Counter with Alarm

This block keeps wall-clock time as a 32-bit count of seconds. An external prescaler supplies a one-cycle `tick_1hz` pulse once per second. Software reaches the block through a small register bank of 32-bit words at byte addresses aligned to 4. Through it, software starts and stops the counter, loads a start time, reads the live time and programs one alarm compare value. When the live time reaches the alarm value, a sticky pending flag is set. The interrupt output is that flag gated by a mask bit, and software acknowledges it by writing a 1 to a clear register.

With the build option `GRAY_STORE` set (the default), the load, alarm and live-time registers hold Gray-coded values (g = b ^ (b >> 1)). The block converts them to binary inside, so counting and comparison happen in plain binary. The run enable is not immediate: it settles after `EN_DELAY` clock cycles, and the run bit reads 1 only once the counter is actually counting.

The register port is a request channel with valid/ready. `req_ready` is always 1, so a request is accepted in every cycle where `req_valid` is high. A read's data returns with `rsp_valid` one cycle after acceptance. The response has no back-pressure, and the requester must take it in that cycle.

Top module: `sec_alarm_timer`

Register map (byte offsets): 0x00 control, 0x04 time load, 0x08 alarm, 0x20 mask, 0x24 clear, 0x30 pending status, 0x34 live time.

## Requirements
- R1: After reset, control reads 0, mask bit 0 reads 1, status reads 0, live time reads 0 and `alarm_irq` is 0.
- R2: `req_ready` is always 1. An accepted read raises `rsp_valid` for exactly the next cycle with the data. Unmapped addresses and the load and clear registers read 0.
- R3: Control bit 12 requests counting. The counter runs only after the bit has been held set for `EN_DELAY` cycles, and bit 12 reads back the running state. Clearing the bit stops counting from the next cycle, and ticks are then ignored.
- R4: While running, each `tick_1hz` cycle adds 1 to the live time. 0xFFFFFFFF wraps to 0.
- R5: Writing the load register (0x04) sets the live time from the next cycle, whether or not the counter runs. A load wins over a tick in the same cycle.
- R6: With `GRAY_STORE`=1, the values written to load and alarm and the value read from live time are Gray-coded, and comparison uses the binary equivalents.
- R7: With control bit 0 set, status bit 0 becomes 1 in the cycle after the live time first equals the alarm value. With bit 0 clear, no alarm is recorded.
- R8: Status bit 0 stays set until a write to 0x24 with bit 0 = 1. A new alarm in the same cycle wins. Remaining equal after a clear does not set it again.
- R9: `alarm_irq` equals status bit 0 AND NOT mask bit 0 (0x20). The status bit is set regardless of the mask.
- R10: Control bit 8 selects the fast reference. It reads back as written and drives `osc_fast_sel`.
- R11: A live-time read returns the whole count as held at the accepting edge. A tick in the same cycle shows only in later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address, low 2 bits ignored |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| alarm_irq | output | 1 | Alarm interrupt |
| osc_fast_sel | output | 1 | Reference oscillator select |

## Verification
The assertions check on every cycle that the count holds or steps by exactly one, that loads land on the next edge, that the pending flag stays set until cleared and drops on a clear, that the run flag falls when the enable drops, that a mask blocks the interrupt, and that each read gets one response. Only the bench's scenarios can show the register-level results. These are the Gray encoding of loaded and read values, the enable delay seen through the run bit, the alarm firing on the right tick and not firing again after a clear, the effect of the enable and mask bits, wrap-around, and a read that coincides with a tick.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int DATA_W = 32;

  // word indices (byte offset / 4)
  localparam int W_CTRL  = 0;
  localparam int W_LOAD  = 1;
  localparam int W_ALARM = 2;
  localparam int W_MASK  = 8;
  localparam int W_CLR   = 9;
  localparam int W_STAT  = 12;
  localparam int W_TIME  = 13;

  // control bit positions
  localparam int B_ALM = 0;
  localparam int B_OSC = 8;
  localparam int B_RUN = 12;

  function automatic logic [DATA_W-1:0] bin2gray(input logic [DATA_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [DATA_W-1:0] gray2bin(input logic [DATA_W-1:0] g);
    logic [DATA_W-1:0] b;
    b[DATA_W-1] = g[DATA_W-1];
    for (int i = DATA_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/sat_enable_sync.sv
module sat_enable_sync #(
  parameter int DELAY_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  output logic running
);
  localparam int CW = $clog2(DELAY_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (!en_req) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (!running) begin
      if (cnt == CW'(DELAY_CYC - 1)) running <= 1'b1;
      else cnt <= cnt + 1'b1;
    end
  end

  // R3
  stop_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_req |=> !running);
  // R3
  start_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(en_req));
endmodule

// File: rtl/sat_time_core.sv
module sat_time_core
  import sat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              load_stb,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] alarm_val,
  output logic [DATA_W-1:0] count,
  output logic              at_alarm
);
  always_ff @(posedge clk) begin
    if (!rst_n)              count <= '0;
    else if (load_stb)       count <= load_val;
    else if (run && tick)    count <= count + 1'b1;
  end

  assign at_alarm = (count == alarm_val);

  // R5
  load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> count == $past(load_val));
  // R4
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !load_stb) |=> count == $past(count) + 1'b1);
  // R3
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_stb && !(run && tick)) |=> $stable(count));
endmodule

// File: rtl/sat_irq_ctrl.sv
module sat_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr_stb,
  input  logic mask,
  output logic pending,
  output logic irq
);
  logic hit_q;
  logic set_ev;

  assign set_ev = hit && !hit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q   <= 1'b0;
      pending <= 1'b0;
    end else begin
      hit_q <= hit;
      if (set_ev)       pending <= 1'b1;
      else if (clr_stb) pending <= 1'b0;
    end
  end

  assign irq = pending && !mask;

  // R8
  sticky_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clr_stb) |=> pending);
  // R8
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !set_ev) |=> !pending);
endmodule

// File: rtl/sec_alarm_timer.sv
module sec_alarm_timer
  import sat_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter bit GRAY_STORE = 1'b1,
  parameter int EN_DELAY   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              alarm_irq,
  output logic              osc_fast_sel
);
  localparam int WA_W = ADDR_W - 2;

  logic [WA_W-1:0]   word;
  logic              wr_acc, rd_acc;
  logic              alm_en, osc_sel, en_req, mask_q;
  logic [DATA_W-1:0] alarm_raw;
  logic [DATA_W-1:0] load_bin, alarm_bin, time_view;
  logic [DATA_W-1:0] count;
  logic              running, at_alarm, pending;
  logic              load_stb, clr_stb;

  assign req_ready = 1'b1;
  assign word      = req_addr[ADDR_W-1:2];
  assign wr_acc    = req_valid && req_write;
  assign rd_acc    = req_valid && !req_write;
  assign load_stb  = wr_acc && (word == WA_W'(W_LOAD));
  assign clr_stb   = wr_acc && (word == WA_W'(W_CLR)) && req_wdata[0];

  generate
    if (GRAY_STORE) begin : g_gray
      assign load_bin  = gray2bin(req_wdata);
      assign alarm_bin = gray2bin(alarm_raw);
      assign time_view = bin2gray(count);
    end else begin : g_bin
      assign load_bin  = req_wdata;
      assign alarm_bin = alarm_raw;
      assign time_view = count;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alm_en    <= 1'b0;
      osc_sel   <= 1'b0;
      en_req    <= 1'b0;
      mask_q    <= 1'b1;
      alarm_raw <= '0;
    end else if (wr_acc) begin
      if (word == WA_W'(W_CTRL)) begin
        alm_en  <= req_wdata[B_ALM];
        osc_sel <= req_wdata[B_OSC];
        en_req  <= req_wdata[B_RUN];
      end
      if (word == WA_W'(W_ALARM)) alarm_raw <= req_wdata;
      if (word == WA_W'(W_MASK))  mask_q    <= req_wdata[0];
    end
  end

  sat_enable_sync #(.DELAY_CYC(EN_DELAY)) u_ensync (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .running(running)
  );

  sat_time_core u_core (
    .clk(clk), .rst_n(rst_n), .run(running), .tick(tick_1hz),
    .load_stb(load_stb), .load_val(load_bin), .alarm_val(alarm_bin),
    .count(count), .at_alarm(at_alarm)
  );

  sat_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n), .hit(alm_en && at_alarm), .clr_stb(clr_stb),
    .mask(mask_q), .pending(pending), .irq(alarm_irq)
  );

  assign osc_fast_sel = osc_sel;

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (int'(word))
      W_CTRL: begin
        rd_mux[B_ALM] = alm_en;
        rd_mux[B_OSC] = osc_sel;
        rd_mux[B_RUN] = running;
      end
      W_ALARM: rd_mux = alarm_raw;
      W_MASK:  rd_mux[0] = mask_q;
      W_STAT:  rd_mux[0] = pending;
      W_TIME:  rd_mux = time_view;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_acc;
      if (rd_acc) rsp_rdata <= rd_mux;
    end
  end

  // R2
  read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rsp_valid);
  // R2
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !rsp_valid);
  // R9
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> !alarm_irq);
endmodule

// File: tb/sim_sec_alarm_timer.sv
`timescale 1ns/1ps
module sim_sec_alarm_timer;
  localparam int ADDR_W = 6;
  localparam int EN_DELAY = 8;

  logic clk = 1'b0, rst_n = 1'b0, tick_1hz = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, alarm_irq, osc_fast_sel;
  logic [31:0] rsp_rdata;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_t, rd;

  always #4 clk = ~clk;

  sec_alarm_timer #(.ADDR_W(ADDR_W), .GRAY_STORE(1'b1), .EN_DELAY(EN_DELAY)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .alarm_irq(alarm_irq), .osc_fast_sel(osc_fast_sel)
  );

  localparam logic [5:0] A_CTRL = 6'h00, A_LOAD = 6'h04, A_ALM = 6'h08,
    A_MASK = 6'h20, A_CLR = 6'h24, A_STAT = 6'h30, A_TIME = 6'h34;

  function automatic logic [31:0] g_of(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rdreg(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_valid ? rsp_rdata : 32'hDEAD_BEEF;
  endtask

  task automatic tick();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R2 ready", {31'd0, req_ready}, 32'd1);
    rdreg(A_CTRL, rd); check("R1 ctrl", rd, 32'd0);
    rdreg(A_MASK, rd); check("R1 mask", rd, 32'd1);
    rdreg(A_STAT, rd); check("R1 status", rd, 32'd0);
    rdreg(A_TIME, rd); check("R1 time", rd, 32'd0);
    check("R1 irq", {31'd0, alarm_irq}, 32'd0);
    rdreg(6'h14, rd); check("R2 unmapped", rd, 32'd0);

    // R3 ticks ignored while stopped
    tick(); rdreg(A_TIME, rd); check("R3 stopped", rd, 32'd0);

    // R3 enable delay
    wr(A_CTRL, 32'h1000);
    rdreg(A_CTRL, rd); check("R3 not yet running", rd, 32'd0);
    repeat (EN_DELAY + 4) @(negedge clk);
    rdreg(A_CTRL, rd); check("R3 running", rd, 32'h1000);
    tick(); rdreg(A_TIME, rd); check("R4 first tick", rd, g_of(32'd1));

    // R5 R6 random loads and ticks
    for (int i = 0; i < 16; i++) begin
      logic [31:0] v;
      int n;
      v = $urandom;
      n = $urandom_range(0, 4);
      wr(A_LOAD, g_of(v));
      for (int k = 0; k < n; k++) tick();
      rdreg(A_TIME, rd); check("R6 gray load/tick", rd, g_of(v + 32'(n)));
    end
    rdreg(A_LOAD, rd); check("R2 load reads 0", rd, 32'd0);

    // R4 wrap
    wr(A_LOAD, g_of(32'hFFFF_FFFF));
    tick(); rdreg(A_TIME, rd); check("R4 wrap", rd, g_of(32'd0));

    // R5 load beats tick
    @(negedge clk);
    tick_1hz = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_addr = A_LOAD; req_wdata = g_of(32'd500);
    @(negedge clk);
    tick_1hz = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    rdreg(A_TIME, rd); check("R5 load priority", rd, g_of(32'd500));

    // R11 read coincides with tick
    @(negedge clk);
    tick_1hz = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_addr = A_TIME;
    @(negedge clk);
    tick_1hz = 1'b0; req_valid = 1'b0;
    check("R11 snapshot", rsp_rdata, g_of(32'd500));
    rdreg(A_TIME, rd); check("R11 after", rd, g_of(32'd501));

    // R7 R9 alarm
    exp_t = 32'd1000;
    wr(A_LOAD, g_of(exp_t));
    wr(A_CTRL, 32'h1001);
    wr(A_MASK, 32'd0);
    wr(A_ALM, g_of(exp_t + 3));
    rdreg(A_ALM, rd); check("R6 alarm readback", rd, g_of(exp_t + 3));
    tick(); tick();
    @(negedge clk);
    check("R7 not early", {31'd0, alarm_irq}, 32'd0);
    tick();
    @(negedge clk);
    check("R9 irq raised", {31'd0, alarm_irq}, 32'd1);
    rdreg(A_STAT, rd); check("R7 status set", rd, 32'd1);

    // R8 clear, no refire while equal
    wr(A_CLR, 32'd1);
    rdreg(A_STAT, rd); check("R8 cleared", rd, 32'd0);
    repeat (3) @(negedge clk);
    check("R8 no refire", {31'd0, alarm_irq}, 32'd0);

    // R9 masked alarm still records status
    wr(A_MASK, 32'd1);
    wr(A_ALM, g_of(exp_t + 5));
    tick(); tick();
    @(negedge clk);
    rdreg(A_STAT, rd); check("R9 status while masked", rd, 32'd1);
    check("R9 irq masked", {31'd0, alarm_irq}, 32'd0);
    wr(A_MASK, 32'd0);
    check("R9 irq unmasked", {31'd0, alarm_irq}, 32'd1);
    wr(A_CLR, 32'd1);

    // R7 alarm enable off
    wr(A_CTRL, 32'h1000);
    wr(A_ALM, g_of(exp_t + 7));
    tick(); tick();
    @(negedge clk);
    rdreg(A_STAT, rd); check("R7 disabled alarm", rd, 32'd0);
    rdreg(A_TIME, rd); check("R7 time reached", rd, g_of(exp_t + 7));

    // R10 oscillator select
    wr(A_CTRL, 32'h1100);
    rdreg(A_CTRL, rd); check("R10 readback", rd, 32'h1100);
    check("R10 pin", {31'd0, osc_fast_sel}, 32'd1);

    // R3 stop, R5 load while stopped
    wr(A_CTRL, 32'h0);
    rdreg(A_CTRL, rd); check("R3 stopped readback", rd, 32'd0);
    tick(); rdreg(A_TIME, rd); check("R3 tick ignored", rd, g_of(exp_t + 7));
    wr(A_LOAD, g_of(32'd77));
    rdreg(A_TIME, rd); check("R5 load while stopped", rd, g_of(32'd77));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule